// File: doc/BRIEF.md
# Narrow-Port Flash Direct-Control Register Bank

This block lets an external programmer drive a flash array's wide direct-control interface through a few pins. The external side has an 8-bit bidirectional data port, a 3-bit register select and a clock. The array side has a 10-bit row address, a 6-bit column address, an 8-bit write-data byte, ten control strobes, and the array's 8-bit read data. The select code on each rising clock edge decides where the data goes. Five codes load slices of the array-side registers from the port. One code captures the array's read data and turns the port into an output. The two remaining codes do nothing.

The register map is fixed. The row address is split across two codes, and one of those codes also carries the column address. The strobes are packed into two registers. The port has no handshake. Every rising edge with a loading code is one complete transfer. The block never applies back-pressure, so the external side simply presents one register per clock. The pad is modelled as separate input, output and output-enable signals.

Top module: `flash_bypass_bank`

## Requirements
- R1: After reset, every array-side output (row, column, write data, all ten strobes) is 0, the captured output byte is 0, and the port is not driven (`pad_oe` = 0 for any select other than 5).
- R2: On a rising edge with select 0, `row_addr[9:2]` takes `pad_in[7:0]`.
- R3: On a rising edge with select 1, `row_addr[1:0]` takes `pad_in[7:6]` and `col_addr[5:0]` takes `pad_in[5:0]`.
- R4: On a rising edge with select 2, `wr_data` takes `pad_in`.
- R5: On a rising edge with select 3, the strobes take `pad_in` with this bit mapping: bit 7 `x_en`, bit 6 `y_en`, bit 5 `sense_en`, bit 4 `out_en`, bit 3 `erase_en`, bit 2 `prog_en`, bit 1 `mass_sel`, bit 0 `nv_store`.
- R6: On a rising edge with select 4, `test_mode` takes `pad_in[7]` and `info_sel` takes `pad_in[6]`. Bits 5..0 are ignored.
- R7: Selects 6 and 7 change no array-side output and do not change the captured byte.
- R8: A load changes only the fields named for its own select code. Every other field holds its value.
- R9: On a rising edge with select 5, `arr_rdata` is captured. From that edge on, `pad_out` shows the captured byte, and `pad_oe` is 1 exactly while the select is 5.
- R10: Select 5 changes none of the array-side outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External register clock; loads and captures happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Register select code |
| pad_in | input | 8 | Data arriving from the pad |
| pad_out | output | 8 | Captured read byte toward the pad |
| pad_oe | output | 1 | Pad output enable; high only for select 5 |
| arr_rdata | input | 8 | Read data from the flash array |
| row_addr | output | 10 | Row address to the array |
| col_addr | output | 6 | Column (byte-in-row) address to the array |
| wr_data | output | 8 | Write data to the array |
| x_en | output | 1 | Row address enable |
| y_en | output | 1 | Column address enable |
| sense_en | output | 1 | Sense amplifier enable |
| out_en | output | 1 | Array output enable |
| erase_en | output | 1 | Erase operation select |
| prog_en | output | 1 | Program operation select |
| mass_sel | output | 1 | Mass versus page erase select |
| nv_store | output | 1 | Non-volatile store enable |
| test_mode | output | 1 | Test-mode control bit |
| info_sel | output | 1 | Information area select |

## Verification
Every register drives a port directly. A decode fault or a slice fault therefore shows on the array-side outputs one clock after the wrong load. A bad enable that lets an ignored code or the read code write a register also shows one edge later, as an unexpected change on a field that should have held. A fault in the capture path shows on `pad_out` in the cycle right after a select-5 edge. A fault in the enable decode shows on `pad_oe` combinationally, as soon as the select changes.

// File: rtl/fbb_pkg.sv
package fbb_pkg;
  localparam int DW     = 8;
  localparam int SEL_W  = 3;
  localparam int ROW_W  = DW + 2;
  localparam int COL_W  = DW - 2;
  localparam int MODE_W = 2;
  localparam int NLOAD  = 5;

  typedef enum logic [SEL_W-1:0] {
    SEL_ROW_HI  = 3'd0,
    SEL_ROW_COL = 3'd1,
    SEL_WDATA   = 3'd2,
    SEL_STROBE  = 3'd3,
    SEL_MODE    = 3'd4,
    SEL_READ    = 3'd5
  } sel_code_e;

  typedef struct packed {
    logic x_en;
    logic y_en;
    logic sense_en;
    logic out_en;
    logic erase_en;
    logic prog_en;
    logic mass_sel;
    logic nv_store;
  } strobe_t;
endpackage

// File: rtl/fbb_decode.sv
module fbb_decode
  import fbb_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output logic [NLOAD-1:0] load_en,
  output logic             read_sel
);
  for (genvar i = 0; i < NLOAD; i++) begin : g_ld
    assign load_en[i] = (sel == SEL_W'(i));
  end
  assign read_sel = (sel == SEL_READ);
endmodule

// File: rtl/fbb_regs.sv
module fbb_regs
  import fbb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLOAD-1:0]  load_en,
  input  logic [DW-1:0]     din,
  output logic [ROW_W-1:0]  row_q,
  output logic [COL_W-1:0]  col_q,
  output logic [DW-1:0]     wdata_q,
  output strobe_t           strobe_q,
  output logic [MODE_W-1:0] mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q    <= '0;
      col_q    <= '0;
      wdata_q  <= '0;
      strobe_q <= '0;
      mode_q   <= '0;
    end else begin
      if (load_en[SEL_ROW_HI])  row_q[ROW_W-1:2] <= din;
      if (load_en[SEL_ROW_COL]) begin
        row_q[1:0] <= din[DW-1:DW-2];
        col_q      <= din[COL_W-1:0];
      end
      if (load_en[SEL_WDATA])   wdata_q  <= din;
      if (load_en[SEL_STROBE])  strobe_q <= strobe_t'(din);
      if (load_en[SEL_MODE])    mode_q   <= din[DW-1:DW-MODE_W];
    end
  end
endmodule

// File: rtl/fbb_capture.sv
module fbb_capture
  import fbb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          read_sel,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] cap_q,
  output logic          drive
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap_q <= '0;
    else if (read_sel) cap_q <= arr_rdata;
  end
  assign drive = read_sel;
endmodule

// File: rtl/flash_bypass_bank.sv
module flash_bypass_bank
  import fbb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    sel,
  input  logic [DW-1:0]       pad_in,
  output logic [DW-1:0]       pad_out,
  output logic                pad_oe,
  input  logic [DW-1:0]       arr_rdata,
  output logic [ROW_W-1:0]    row_addr,
  output logic [COL_W-1:0]    col_addr,
  output logic [DW-1:0]       wr_data,
  output logic                x_en,
  output logic                y_en,
  output logic                sense_en,
  output logic                out_en,
  output logic                erase_en,
  output logic                prog_en,
  output logic                mass_sel,
  output logic                nv_store,
  output logic                test_mode,
  output logic                info_sel
);
  logic [NLOAD-1:0]  load_en;
  logic              read_sel;
  strobe_t           strobe_q;
  logic [MODE_W-1:0] mode_q;

  fbb_decode u_dec (
    .sel      (sel),
    .load_en  (load_en),
    .read_sel (read_sel)
  );

  fbb_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .din      (pad_in),
    .row_q    (row_addr),
    .col_q    (col_addr),
    .wdata_q  (wr_data),
    .strobe_q (strobe_q),
    .mode_q   (mode_q)
  );

  fbb_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .read_sel  (read_sel),
    .arr_rdata (arr_rdata),
    .cap_q     (pad_out),
    .drive     (pad_oe)
  );

  assign x_en      = strobe_q.x_en;
  assign y_en      = strobe_q.y_en;
  assign sense_en  = strobe_q.sense_en;
  assign out_en    = strobe_q.out_en;
  assign erase_en  = strobe_q.erase_en;
  assign prog_en   = strobe_q.prog_en;
  assign mass_sel  = strobe_q.mass_sel;
  assign nv_store  = strobe_q.nv_store;
  assign test_mode = mode_q[1];
  assign info_sel  = mode_q[0];
endmodule

// File: rtl/fbb_checker.sv
module fbb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] sel,
  input logic [7:0] pad_in,
  input logic [7:0] pad_out,
  input logic       pad_oe,
  input logic [7:0] arr_rdata,
  input logic [9:0] row_addr,
  input logic [5:0] col_addr,
  input logic [7:0] wr_data,
  input logic       x_en,
  input logic       y_en,
  input logic       sense_en,
  input logic       out_en,
  input logic       erase_en,
  input logic       prog_en,
  input logic       mass_sel,
  input logic       nv_store,
  input logic       test_mode,
  input logic       info_sel
);
  logic [7:0] strobes;
  logic [33:0] arr_side;
  assign strobes  = {x_en, y_en, sense_en, out_en, erase_en, prog_en, mass_sel, nv_store};
  assign arr_side = {row_addr, col_addr, wr_data, strobes, test_mode, info_sel};

  a_r2_row_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0) |=> (row_addr[9:2] == $past(pad_in)));
  a_r3_row_col: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd1) |=> ({row_addr[1:0], col_addr} == $past(pad_in)));
  a_r4_wdata: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd2) |=> (wr_data == $past(pad_in)));
  a_r5_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd3) |=> (strobes == $past(pad_in)));
  a_r6_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd4) |=> ({test_mode, info_sel} == $past(pad_in[7:6])));
  a_r7_idle_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[2:1] == 2'b11) |=> ($stable(arr_side) && $stable(pad_out)));
  a_r8_row_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != 3'd0) |=> $stable(row_addr[9:2]));
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd5) |=> (pad_out == $past(arr_rdata)));
  a_r10_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd5) |=> $stable(arr_side));
endmodule

bind flash_bypass_bank fbb_checker u_chk (.*);

// File: tb/tb_flash_bypass_bank.sv
module tb_flash_bypass_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [7:0] pad_in = 8'd0;
  logic [7:0] arr_rdata = 8'd0;
  logic [7:0] pad_out;
  logic       pad_oe;
  logic [9:0] row_addr;
  logic [5:0] col_addr;
  logic [7:0] wr_data;
  logic x_en, y_en, sense_en, out_en, erase_en, prog_en, mass_sel, nv_store, test_mode, info_sel;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [9:0] e_row = '0;
  logic [5:0] e_col = '0;
  logic [7:0] e_wd = '0;
  logic [7:0] e_stb = '0;
  logic [1:0] e_md = '0;
  logic [7:0] e_out = '0;

  always #10 clk = ~clk;

  flash_bypass_bank dut (.*);

  task automatic chk(input string tag, input logic [33:0] act, input logic [33:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_for(input logic [2:0] s, input logic [2:0] own, input string own_tag);
    if (s[2:1] == 2'b11) return "R7";
    if (s == 3'd5) return "R10";
    if (s == own) return own_tag;
    return "R8";
  endfunction

  task automatic model(input logic [2:0] s, input logic [7:0] d, input logic [7:0] a);
    case (s)
      3'd0: e_row[9:2] = d;
      3'd1: begin e_row[1:0] = d[7:6]; e_col = d[5:0]; end
      3'd2: e_wd = d;
      3'd3: e_stb = d;
      3'd4: e_md = d[7:6];
      3'd5: e_out = a;
      default: ;
    endcase
  endtask

  task automatic check_all(input logic [2:0] s);
    chk(tag_for(s, 3'd0, "R2"), 34'(row_addr[9:2]), 34'(e_row[9:2]));
    chk(tag_for(s, 3'd1, "R3"), 34'({row_addr[1:0], col_addr}), 34'({e_row[1:0], e_col}));
    chk(tag_for(s, 3'd2, "R4"), 34'(wr_data), 34'(e_wd));
    chk(tag_for(s, 3'd3, "R5"),
        34'({x_en, y_en, sense_en, out_en, erase_en, prog_en, mass_sel, nv_store}), 34'(e_stb));
    chk(tag_for(s, 3'd4, "R6"), 34'({test_mode, info_sel}), 34'(e_md));
    chk((s == 3'd5) ? "R9" : (s[2:1] == 2'b11) ? "R7" : "R8", 34'(pad_out), 34'(e_out));
  endtask

  // One clock: drive at the falling edge, check after the next falling edge.
  task automatic cyc(input logic [2:0] s, input logic [7:0] d, input logic [7:0] a);
    sel = s; pad_in = d; arr_rdata = a;
    #1;
    chk("R9", 34'(pad_oe), 34'(s == 3'd5));
    @(posedge clk);
    model(s, d, a);
    @(negedge clk);
    check_all(s);
  endtask

  initial begin
    automatic int unsigned seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", 34'({row_addr, col_addr, wr_data}), 34'd0);
    chk("R1", 34'({x_en, y_en, sense_en, out_en, erase_en, prog_en, mass_sel, nv_store, test_mode, info_sel}), 34'd0);
    chk("R1", 34'({pad_out, pad_oe}), 34'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    cyc(3'd0, 8'hA5, 8'h00);           // R2
    cyc(3'd1, 8'hC3, 8'h00);           // R3
    cyc(3'd2, 8'h5A, 8'h00);           // R4
    cyc(3'd3, 8'h81, 8'h00);           // R5 x_en and nv_store
    cyc(3'd3, 8'h7E, 8'h00);           // R5 middle strobes
    cyc(3'd4, 8'hBF, 8'h00);           // R6 low bits ignored
    cyc(3'd4, 8'h40, 8'h00);           // R6
    cyc(3'd6, 8'hFF, 8'h11);           // R7
    cyc(3'd7, 8'h00, 8'h22);           // R7
    cyc(3'd5, 8'hFF, 8'h3C);           // R9, R10
    chk("R9", 34'(pad_out), 34'h3C);
    cyc(3'd5, 8'h00, 8'hE7);           // R9 back-to-back capture
    cyc(3'd2, 8'h00, 8'h99);           // R8 captured byte held
    cyc(3'd0, 8'hFF, 8'h00);           // R8 row low bits held
    cyc(3'd1, 8'h00, 8'h00);           // R8 row high bits held

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      automatic logic [2:0] s = 3'($urandom_range(7, 0));
      cyc(s, 8'($urandom), 8'($urandom));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule